// File: doc/BRIEF.md
# Rename Stage Flow Controller

This block steers instruction groups through the rename stage of a superscalar core. Each cycle decode may present a group of up to `W` instructions, every slot carrying three flags: already squashed, serializing, and needs a destination register. The controller decides which slots go on to issue this cycle and which must wait. It also tells the external register allocator how many physical registers to hand out, and it raises a stall toward decode when it cannot keep up.

Downstream room is judged from credit counts that reach rename `DLY` cycles late. Up to `W` instructions may have been sent in each of those cycles, so the reported free counts are reduced by `W*DLY` before use. A group that only partly fits is split. The unfinished group is held in a skid buffer, and a resume index records the first slot still to process, so the next attempt starts mid-group. Groups that decode keeps sending while the stall travels back are queued in the same buffer. A squash from commit throws all of this pending state away.

Back-pressure rules: the input group (`grp_valid` with a non-zero `grp_cnt`) has no ready. Decode must stop sending within `DLY` cycles of `dec_stall` rising. Every group it sends before that is accepted into the skid buffer, which holds `DLY+2` groups. The output (`iss_valid`, `iss_mask`) has no ready either; issue is protected by the credit rule alone.

Top module: `rename_flow_ctl`

## Requirements
- R1: Usable room is the smaller of `rob_free - W*DLY` and `iq_free - W*DLY`. When a group has work and this room is zero or negative, or `iew_stall` or `cmt_stall` is high, no slot is issued and the stage blocks.
- R2: When room is positive but smaller than the number of slots remaining in the group, at most `room` slots are consumed and the stage blocks at the end of the cycle.
- R3: A slot with its destination flag set is not issued if doing so would make the registers allocated this cycle exceed `preg_free`. Processing stops at that slot and the stage blocks. `reg_alloc` equals the number of issued slots whose destination flag is set.
- R4: Slots flagged squashed are never issued. Each one still uses up one slot of the room limit and advances the position within the group.
- R5: While blocked, barrier-stalled or unblocking, every incoming group with a non-zero count is appended to the skid buffer. Queued groups are processed oldest first.
- R6: While unblocking, processing starts at the resume index of the oldest queued group. The index returns to 0 after a cycle that finishes its group and keeps its new value after a cycle that blocks.
- R7: The stage leaves the blocked state for unblocking only after a cycle with both stall inputs low, positive usable ROB and IQ room, and `preg_free` above zero.
- R8: In a cycle with `squash` high, nothing is issued and `dec_stall` is low. The skid buffer and the resume index are cleared, and the incoming group is dropped.
- R9: A serializing slot is issued and then processing stops. The stage enters a barrier state that it leaves only when the unblock conditions of R7 hold together with `rob_drained`.
- R10: `dec_stall` is high in any cycle spent blocked, barrier-stalled or unblocking, and in any cycle whose processing blocks. It is low otherwise.
- R11: Out of reset, with no group offered, nothing is issued and `dec_stall` is low.
- R12: `iss_mask` bit `k` refers to slot `k` of the group being processed: the queued group while unblocking, the incoming group otherwise. Slots issue lowest index first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grp_valid | input | 1 | Decode presents a group |
| grp_cnt | input | NW | Number of slots in the group (0..W) |
| grp_sq | input | W | Per-slot squashed flag |
| grp_ser | input | W | Per-slot serializing flag |
| grp_dst | input | W | Per-slot needs-destination-register flag |
| rob_free | input | CW | Reported free ROB entries (delayed) |
| iq_free | input | CW | Reported free IQ entries (delayed) |
| preg_free | input | CW | Free physical registers |
| iew_stall | input | 1 | Stall from execute |
| cmt_stall | input | 1 | Stall from commit |
| rob_drained | input | 1 | ROB holds no instructions |
| squash | input | 1 | Squash from commit |
| iss_valid | output | 1 | At least one slot issued this cycle |
| iss_mask | output | W | Slots issued this cycle |
| reg_alloc | output | NW | Physical registers taken this cycle |
| dec_stall | output | 1 | Stall toward decode |

## Verification
A wrong resume index or a skid buffer that loses or reorders a group does not show up at once. It shows up on the first unblocking cycle, typically two to four cycles after the block, as a shifted or duplicated `iss_mask`. A wrong state shows as `dec_stall` disagreeing with the reference in the very next cycle. Credit arithmetic errors show as an over-wide `iss_mask` in the same cycle the credits are low. For these reasons the reference model is compared on every cycle across mixed stall, squash and barrier traffic.

// File: rtl/rnfc_pkg.sv
package rnfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCK   = 3'd2,
    ST_UNBLK   = 3'd3,
    ST_SQUASH  = 3'd4,
    ST_BARRIER = 3'd5
  } rn_state_e;
endpackage

// File: rtl/rnfc_credit.sv
module rnfc_credit #(
  parameter int W   = 4,
  parameter int DLY = 2,
  parameter int CW  = 6
) (
  input  logic [CW-1:0]        rob_free,
  input  logic [CW-1:0]        iq_free,
  input  logic [CW-1:0]        preg_free,
  input  logic                 iew_stall,
  input  logic                 cmt_stall,
  output logic signed [CW+1:0] room,
  output logic                 go,
  output logic                 resume_ok
);
  localparam logic signed [CW+1:0] DISCOUNT = (CW+2)'(W * DLY);

  logic signed [CW+1:0] rob_use, iq_use;

  always_comb begin
    rob_use   = $signed({2'b00, rob_free}) - DISCOUNT;
    iq_use    = $signed({2'b00, iq_free}) - DISCOUNT;
    room      = (rob_use < iq_use) ? rob_use : iq_use;
    go        = !iew_stall && !cmt_stall && (room > 0);
    resume_ok = go && (rob_use > 0) && (iq_use > 0) && (preg_free != '0);
  end
endmodule

// File: rtl/rnfc_skid.sv
module rnfc_skid #(
  parameter int DEPTH = 4,
  parameter int EW    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] dout,
  output logic          empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int KW = $clog2(DEPTH+1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + KW'(push) - KW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> (count < KW'(DEPTH))); // R5
  AST_SKID_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> (count != '0)); // R5
  AST_SKID_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R8
endmodule

// File: rtl/rnfc_group.sv
module rnfc_group #(
  parameter int W  = 4,
  parameter int CW = 6,
  parameter int NW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NW-1:0]        start,
  input  logic [NW-1:0]        avail,
  input  logic signed [CW+1:0] room,
  input  logic                 go,
  input  logic [W-1:0]         sq,
  input  logic [W-1:0]         ser,
  input  logic [W-1:0]         dst,
  input  logic [CW-1:0]        preg_free,
  output logic [W-1:0]         fwd,
  output logic [NW-1:0]        taken,
  output logic [NW-1:0]        alloc,
  output logic                 blk,
  output logic                 bar
);
  always_comb begin
    int st, av, lim, tk, regs, rm;
    logic stop;
    st   = int'(start);
    av   = int'(avail);
    rm   = int'(room);
    lim  = (rm < av) ? rm : av;
    tk   = 0;
    regs = 0;
    stop = 1'b0;
    fwd  = '0;
    blk  = 1'b0;
    bar  = 1'b0;
    if (av > 0 && !go) begin
      blk = 1'b1;
    end else if (av > 0) begin
      blk = (rm < av);
      for (int s = 0; s < W; s++) begin
        if (!stop && s >= st && s < st + av && tk < lim) begin
          if (sq[s]) begin
            tk = tk + 1;
          end else if (dst[s] && (regs + 1 > int'(preg_free))) begin
            blk  = 1'b1;
            stop = 1'b1;
          end else begin
            fwd[s] = 1'b1;
            tk     = tk + 1;
            regs   = regs + int'(dst[s]);
            if (ser[s]) begin
              bar  = 1'b1;
              blk  = 1'b1;
              stop = 1'b1;
            end
          end
        end
      end
    end
    taken = NW'(tk);
    alloc = NW'(regs);
  end

  AST_NO_SQUASHED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd & sq) == '0)); // R4
  AST_ISSUE_WITHIN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd != '0) |-> ($countones(fwd) <= int'(room))); // R2
  AST_ALLOC_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(CW-NW+1){1'b0}}, alloc} <= {1'b0, preg_free})); // R3
endmodule

// File: rtl/rename_flow_ctl.sv
module rename_flow_ctl #(
  parameter int W   = 4,
  parameter int DLY = 2,
  parameter int CW  = 6,
  localparam int NW = $clog2(W+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  input  logic [NW-1:0] grp_cnt,
  input  logic [W-1:0]  grp_sq,
  input  logic [W-1:0]  grp_ser,
  input  logic [W-1:0]  grp_dst,
  input  logic [CW-1:0] rob_free,
  input  logic [CW-1:0] iq_free,
  input  logic [CW-1:0] preg_free,
  input  logic          iew_stall,
  input  logic          cmt_stall,
  input  logic          rob_drained,
  input  logic          squash,
  output logic          iss_valid,
  output logic [W-1:0]  iss_mask,
  output logic [NW-1:0] reg_alloc,
  output logic          dec_stall
);
  import rnfc_pkg::*;

  localparam int DEPTH = DLY + 2;
  localparam int EW    = NW + 3*W;
  localparam int KW    = $clog2(DEPTH+1);

  rn_state_e st_q, st_n;
  logic [NW-1:0] idx_q, idx_n;

  logic signed [CW+1:0] room;
  logic go, resume_ok;
  logic sk_push, sk_pop, sk_clr, sk_empty;
  logic [EW-1:0] sk_din, sk_dout;
  logic [KW-1:0] sk_count;

  logic in_ne, from_skid, active, held;
  logic [NW-1:0] g_cnt, g_start, g_avail, g_taken, g_alloc;
  logic [W-1:0]  g_sq, g_ser, g_dst, g_fwd;
  logic g_blk, g_bar;

  rnfc_credit #(.W(W), .DLY(DLY), .CW(CW)) u_credit (
    .rob_free(rob_free), .iq_free(iq_free), .preg_free(preg_free),
    .iew_stall(iew_stall), .cmt_stall(cmt_stall),
    .room(room), .go(go), .resume_ok(resume_ok)
  );

  rnfc_skid #(.DEPTH(DEPTH), .EW(EW)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr(sk_clr), .push(sk_push), .pop(sk_pop),
    .din(sk_din), .dout(sk_dout), .empty(sk_empty), .count(sk_count)
  );

  rnfc_group #(.W(W), .CW(CW), .NW(NW)) u_group (
    .clk(clk), .rst_n(rst_n), .start(g_start), .avail(g_avail), .room(room),
    .go(go), .sq(g_sq), .ser(g_ser), .dst(g_dst), .preg_free(preg_free),
    .fwd(g_fwd), .taken(g_taken), .alloc(g_alloc), .blk(g_blk), .bar(g_bar)
  );

  assign sk_din    = {grp_cnt, grp_sq, grp_ser, grp_dst};
  assign in_ne     = grp_valid && (grp_cnt != '0);
  assign from_skid = (st_q == ST_UNBLK);
  assign held      = (st_q == ST_BLOCK) || (st_q == ST_BARRIER) || (st_q == ST_UNBLK);

  always_comb begin
    if (from_skid) begin
      {g_cnt, g_sq, g_ser, g_dst} = sk_dout;
      g_start = idx_q;
      g_avail = sk_empty ? '0 : (g_cnt - idx_q);
    end else begin
      g_cnt   = grp_cnt;
      g_sq    = grp_sq;
      g_ser   = grp_ser;
      g_dst   = grp_dst;
      g_start = '0;
      g_avail = in_ne ? grp_cnt : '0;
    end
  end

  assign active = !squash && (from_skid ||
                  (((st_q == ST_IDLE) || (st_q == ST_RUN) || (st_q == ST_SQUASH)) && in_ne));

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    sk_push = 1'b0;
    sk_pop  = 1'b0;
    sk_clr  = 1'b0;
    if (squash) begin
      st_n   = ST_SQUASH;
      idx_n  = '0;
      sk_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_BLOCK, ST_BARRIER: begin
          sk_push = in_ne;
          if (resume_ok && (st_q == ST_BLOCK || rob_drained)) st_n = ST_UNBLK;
        end
        ST_UNBLK: begin
          sk_push = in_ne;
          if (g_blk) begin
            st_n  = g_bar ? ST_BARRIER : ST_BLOCK;
            idx_n = idx_q + g_taken;
          end else begin
            sk_pop = !sk_empty;
            idx_n  = '0;
            st_n   = ((int'(sk_count) - int'(sk_pop) + int'(sk_push)) != 0) ? ST_UNBLK : ST_RUN;
          end
        end
        default: begin
          if (in_ne) begin
            if (g_blk) begin
              sk_push = 1'b1;
              st_n    = g_bar ? ST_BARRIER : ST_BLOCK;
              idx_n   = g_taken;
            end else begin
              st_n  = ST_RUN;
              idx_n = '0;
            end
          end else begin
            st_n = ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
    end
  end

  assign iss_mask  = active ? g_fwd : '0;
  assign iss_valid = (iss_mask != '0);
  assign reg_alloc = active ? g_alloc : '0;
  assign dec_stall = !squash && (held || (active && g_blk));

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (!iss_valid && !dec_stall)); // R8
  AST_BLOCK_RAISES_STALL: assert property (@(posedge clk) disable iff (!rst_n || squash)
    (active && g_blk) |=> dec_stall); // R10
  AST_BARRIER_WAITS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BARRIER && !rob_drained && !squash) |=> (st_q == ST_BARRIER)); // R9
  AST_RESUME_INSIDE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (from_skid && !sk_empty) |-> (idx_q <= g_cnt)); // R6
endmodule

// File: tb/rename_flow_ctl_bench.sv
module rename_flow_ctl_bench;
  localparam int W = 4, DLY = 2, CW = 6, NW = 3, DEPTH = DLY + 2;
  localparam int S_IDLE = 0, S_RUN = 1, S_BLOCK = 2, S_UNBLK = 3, S_SQ = 4, S_BAR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic grp_valid = 0; logic [NW-1:0] grp_cnt = 0;
  logic [W-1:0] grp_sq = 0, grp_ser = 0, grp_dst = 0;
  logic [CW-1:0] rob_free = 0, iq_free = 0, preg_free = 0;
  logic iew_stall = 0, cmt_stall = 0, rob_drained = 0, squash = 0;
  logic iss_valid; logic [W-1:0] iss_mask; logic [NW-1:0] reg_alloc; logic dec_stall;

  always #10 clk = ~clk;

  rename_flow_ctl #(.W(W), .DLY(DLY), .CW(CW)) u_rename_flow_ctl (.*);

  typedef struct { int cnt; int sq; int ser; int dst; } grp_t;
  grp_t q[$];
  int mst = S_IDLE, midx = 0, nst, nidx;
  int e_valid, e_mask, e_alloc, e_stall;
  string tag;
  int checks = 0, fails = 0, cyc = 0;
  logic hist [DLY];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_eval();
    grp_t g, inc;
    int start, avail, room, rob_u, iq_u, lim, tk, regs, blk, bar, inne, go;
    inc = '{int'(grp_cnt), int'(grp_sq), int'(grp_ser), int'(grp_dst)};
    inne = grp_valid && grp_cnt != 0;
    rob_u = int'(rob_free) - W*DLY; iq_u = int'(iq_free) - W*DLY;
    room = (rob_u < iq_u) ? rob_u : iq_u;
    go = !iew_stall && !cmt_stall && room > 0;
    e_valid = 0; e_mask = 0; e_alloc = 0; e_stall = 0;
    nst = mst; nidx = midx; tag = "R12";
    if (squash) begin
      nst = S_SQ; nidx = 0; q.delete(); tag = "R8";
      return;
    end
    if (mst == S_BLOCK || mst == S_BAR) begin
      e_stall = 1;
      tag = (mst == S_BAR) ? "R9" : "R7";
      if (inne) begin q.push_back(inc); tag = "R5"; end
      if (go && rob_u > 0 && iq_u > 0 && preg_free != 0 && (mst == S_BLOCK || rob_drained))
        nst = S_UNBLK;
      return;
    end
    if (mst == S_UNBLK) begin
      tag = "R6";
      if (q.size() > 0) begin g = q[0]; start = midx; avail = g.cnt - midx; end
      else begin g = inc; start = 0; avail = 0; end
    end else begin
      if (!inne) begin nst = S_IDLE; return; end
      g = inc; start = 0; avail = inc.cnt;
    end
    blk = 0; bar = 0; tk = 0; regs = 0;
    if (avail > 0 && !go) begin blk = 1; tag = "R1"; end
    else if (avail > 0) begin
      lim = (room < avail) ? room : avail;
      if (room < avail) begin blk = 1; tag = "R2"; end
      for (int s = start; s < start + avail && tk < lim; s++) begin
        if (g.sq[s]) begin tk++; tag = "R4"; end
        else if (g.dst[s] && regs + 1 > int'(preg_free)) begin blk = 1; tag = "R3"; break; end
        else begin
          e_mask |= (1 << s); tk++; regs += g.dst[s];
          if (g.ser[s]) begin bar = 1; blk = 1; tag = "R9"; break; end
        end
      end
    end
    e_valid = (e_mask != 0); e_alloc = regs;
    e_stall = (mst == S_UNBLK) || blk;
    if (mst == S_UNBLK) begin
      if (blk) begin
        if (inne) q.push_back(inc);
        nst = bar ? S_BAR : S_BLOCK; nidx = midx + tk;
      end else begin
        if (q.size() > 0) void'(q.pop_front());
        if (inne) q.push_back(inc);
        nidx = 0; nst = (q.size() > 0) ? S_UNBLK : S_RUN;
      end
    end else if (blk) begin
      q.push_back(inc); nst = bar ? S_BAR : S_BLOCK; nidx = tk;
    end else begin
      nst = S_RUN; nidx = 0;
    end
  endtask

  // one cycle: inputs already set at negedge
  task automatic step();
    if (hist[DLY-1]) grp_valid = 1'b0;   // decode sees the stall DLY cycles late
    #2;
    model_eval();
    check(tag, "iss_valid", int'(iss_valid), e_valid);
    check(tag, "iss_mask", int'(iss_mask), e_mask);
    check("R12", "reg_alloc", int'(reg_alloc), e_alloc);
    check("R10", "dec_stall", int'(dec_stall), e_stall);
    if (q.size() > DEPTH) begin
      fails++; $display("FAIL R5 skid occupancy actual=%0d expected<=%0d", q.size(), DEPTH);
    end
    for (int i = DLY-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = dec_stall;
    @(posedge clk);
    mst = nst; midx = nidx; cyc++;
    @(negedge clk);
  endtask

  task automatic set_in(int v, int c, int sq, int ser, int dst,
                        int rob, int iq, int pr, int st_e, int st_c, int drn, int sqh);
    grp_valid = v[0]; grp_cnt = NW'(c); grp_sq = W'(sq); grp_ser = W'(ser); grp_dst = W'(dst);
    rob_free = CW'(rob); iq_free = CW'(iq); preg_free = CW'(pr);
    iew_stall = st_e[0]; cmt_stall = st_c[0]; rob_drained = drn[0]; squash = sqh[0];
  endtask

  task automatic idle_until_free();
    for (int i = 0; i < 12; i++) begin
      set_in(0, 0, 0, 0, 0, 40, 40, 40, 0, 0, 1, 0);
      step();
    end
  endtask

  initial begin
    for (int i = 0; i < DLY; i++) hist[i] = 1'b0;
    @(negedge clk);
    // R11: reset state
    for (int i = 0; i < 3; i++) begin
      #2;
      check("R11", "iss_valid in reset", int'(iss_valid), 0);
      check("R11", "dec_stall in reset", int'(dec_stall), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // main flow, ample credit
    set_in(1, 4, 0, 0, 4'hF, 40, 40, 40, 0, 0, 1, 0); step();
    set_in(1, 2, 0, 0, 4'h1, 40, 40, 40, 0, 0, 1, 0); step();
    set_in(1, 3, 0, 0, 4'h0, 40, 40, 40, 0, 0, 1, 0); step();
    // R1: credit exactly consumed by the discount
    set_in(1, 3, 0, 0, 0, W*DLY, 40, 40, 0, 0, 1, 0); step();
    idle_until_free();
    // R2: room of 2 against 4 slots, then resume (R6)
    set_in(1, 4, 0, 0, 4'hF, W*DLY + 2, 40, 40, 0, 0, 1, 0); step();
    set_in(1, 2, 0, 0, 0, W*DLY + 2, 40, 40, 0, 0, 1, 0); step();
    idle_until_free();
    // R3: two registers free, all slots need one
    set_in(1, 4, 0, 0, 4'hF, 40, 40, 2, 0, 0, 1, 0); step();
    set_in(0, 0, 0, 0, 0, 40, 40, 2, 0, 0, 1, 0); step();
    idle_until_free();
    // R4: squashed slots skipped and counted against room
    set_in(1, 4, 4'b0101, 0, 4'hF, 40, 40, 40, 0, 0, 1, 0); step();
    set_in(1, 4, 4'b0011, 0, 0, W*DLY + 3, 40, 40, 0, 0, 1, 0); step();
    idle_until_free();
    // R9: serializing slot, barrier holds until drained
    set_in(1, 4, 0, 4'b0010, 0, 40, 40, 40, 0, 0, 0, 0); step();
    for (int i = 0; i < 4; i++) begin set_in(0, 0, 0, 0, 0, 40, 40, 40, 0, 0, 0, 0); step(); end
    idle_until_free();
    // R7: downstream stall keeps the stage blocked
    set_in(1, 4, 0, 0, 0, 40, 40, 40, 1, 0, 1, 0); step();
    for (int i = 0; i < 3; i++) begin set_in(1, 1, 0, 0, 0, 40, 40, 40, 0, 1, 1, 0); step(); end
    idle_until_free();
    // R8: squash while blocked with queued groups
    set_in(1, 4, 0, 0, 0, W*DLY + 1, 40, 40, 0, 0, 1, 0); step();
    set_in(1, 3, 0, 0, 0, 0, 40, 40, 0, 0, 1, 0); step();
    set_in(1, 2, 0, 0, 0, 40, 40, 40, 0, 0, 1, 1); step();
    idle_until_free();
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      int rob, pr;
      rob = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 14) : $urandom_range(10, 60);
      pr  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : $urandom_range(4, 60);
      set_in(int'($urandom_range(0, 3) != 0), $urandom_range(0, W),
             ($urandom_range(0, 5) == 0) ? $urandom_range(0, 15) : 0,
             ($urandom_range(0, 9) == 0) ? (1 << $urandom_range(0, W-1)) : 0,
             $urandom_range(0, 15), rob, $urandom_range(8, 60), pr,
             int'($urandom_range(0, 19) == 0), int'($urandom_range(0, 19) == 0),
             int'($urandom_range(0, 2) == 0), int'($urandom_range(0, 49) == 0));
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule